// File: doc/BRIEF.md
# Card Data FIFO with Threshold DMA Requests

This block is the data buffer between the host bus and the card-side serialiser of a memory-card host controller. It stores up to 32 words of 16 bits. The direction bit picks which side fills and which side drains. In receive, the card side pushes and the host pops. In transmit, the host pushes and the card side pops. Both read ports always present the word at the head of the buffer.

A 16-bit buffer configuration register holds two fill thresholds and a DMA enable for each direction. In receive, a fill level above the almost-full threshold asks the host to drain the buffer. In transmit, a fill level below the almost-empty threshold asks the host to refill it. Each request goes out on exactly one of two outputs: the DMA request line when DMA is enabled for that direction, or the status flag when it is not. Both outputs stay low while the block is idle, meaning no transfer is active and the buffer is empty.

The outputs are combinational functions of the registered fill level, the configuration, the direction and the transfer-active input. They therefore follow each accepted push or pop in the cycle after the clock edge that applied it.

Top module: `xfer_fifo_dreq`

## Requirements
- R1: After a synchronous active-low reset the fill level is 0, the configuration reads 0x1F00 (almost-full 31, almost-empty 0, both DMA enables off), and all four request outputs are low.
- R2: Words leave in the order they entered. The read and write positions wrap modulo 32, so a stream longer than 32 words stays in order.
- R3: A push while the fill level is 32 is dropped, even if a pop is accepted in the same cycle. The fill level never exceeds 32.
- R4: A pop while the buffer is empty leaves the fill level at 0 and leaves the presented head word unchanged.
- R5: With the direction bit at 1 (receive), only the card push and the host pop act. With it at 0 (transmit), only the host push and the card pop act. The other two strobes are ignored.
- R6: In receive, when the fill level is greater than the almost-full threshold, the receive DMA request is high if receive DMA is enabled. Otherwise the receive flag is high.
- R7: In transmit, when the fill level is less than the almost-empty threshold, the transmit DMA request is high if transmit DMA is enabled. Otherwise the transmit flag is high.
- R8: When its condition does not hold, or the direction selects the other side, a side's DMA request and flag are both low.
- R9: When the transfer-active input is low and the fill level is 0, all four request outputs are low, whatever the thresholds are.
- R10: Configuration layout: bit 15 is the receive DMA enable, bits 12:8 the almost-full threshold, bit 7 the transmit DMA enable, bits 4:0 the almost-empty threshold. All other bits read 0. A write that sets a DMA enable clears that side's flag in the cycle the write takes effect.
- R11: A push and a pop accepted in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_rx | input | 1 | 1 = receive (card fills, host drains), 0 = transmit |
| xfer_active | input | 1 | A data transfer is in progress |
| host_push | input | 1 | Host-side word write strobe |
| host_wdata | input | 16 | Host-side write word |
| host_pop | input | 1 | Host-side word read strobe |
| host_rdata | output | 16 | Head word as seen by the host |
| card_push | input | 1 | Card-side word write strobe |
| card_wdata | input | 16 | Card-side write word |
| card_pop | input | 1 | Card-side word read strobe |
| card_rdata | output | 16 | Head word as seen by the card side |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration register write value |
| cfg_rdata | output | 16 | Configuration register read value |
| fill_level | output | 6 | Number of stored words, 0 to 32 |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_flag | output | 1 | Receive threshold status flag |
| tx_flag | output | 1 | Transmit threshold status flag |

## Verification
The hardest states to reach from the ports are where the boundaries meet. One is a completely full buffer that gets a push and a pop in the same cycle, with its pointers already wrapped. The other is the transmit threshold met on an empty buffer just as the transfer-active input changes. Directed sequences overfill the buffer, drain it through the wrap point, and then toggle the active input with a non-zero almost-empty threshold. A long seeded random phase follows. It flips direction, DMA enables and thresholds in the middle of streams, while a ring-buffer model in the bench predicts every output each cycle.

// File: rtl/xfer_fifo_pkg.sv
// Package: shared direction encoding and configuration field positions
// for the card data FIFO. Assumes the level fields are no wider than 5 bits.
package xfer_fifo_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    localparam int CFG_W         = 16;
    localparam int RX_DMA_BIT    = 15;
    localparam int FULL_LVL_LSB  = 8;
    localparam int TX_DMA_BIT    = 7;
    localparam int EMPTY_LVL_LSB = 0;

endpackage

// File: rtl/xfer_fifo_store.sv
// Module: ring-buffer storage with fill counter.
// Assumes push and pop are already qualified by direction. A push at full
// is dropped even when a pop is accepted in the same cycle. A pop at empty
// is ignored. rdata always shows the slot under the read pointer.
module xfer_fifo_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    // Accept strobes only when there is room or data.
    always_comb begin
        push_ok = push && (count != CW'(DEPTH));
        pop_ok  = pop  && (count != '0);
    end

    // Write the incoming word into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers with modulo-DEPTH wrap and track the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    // Present the head word; stale when empty.
    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/xfer_fifo_cfg.sv
// Module: buffer configuration register holding thresholds and DMA enables.
// Assumes the level width fits the 5-bit fields of the 16-bit layout.
// Reserved bits are masked to zero on write.
module xfer_fifo_cfg
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             rx_dma,
    output logic [LW-1:0]    full_lvl,
    output logic             tx_dma,
    output logic [LW-1:0]    empty_lvl
);

    localparam logic [CFG_W-1:0] LVL_ONES  = CFG_W'((1 << LW) - 1);
    localparam logic [CFG_W-1:0] WR_MASK   = (CFG_W'(1) << RX_DMA_BIT)
                                           | (LVL_ONES << FULL_LVL_LSB)
                                           | (CFG_W'(1) << TX_DMA_BIT)
                                           | (LVL_ONES << EMPTY_LVL_LSB);
    localparam logic [CFG_W-1:0] RST_VALUE = CFG_W'(DEPTH - 1) << FULL_LVL_LSB;

    logic [CFG_W-1:0] cfg_q;

    // Hold the register; reserved bits never store a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_VALUE;
        end else if (we) begin
            cfg_q <= wdata & WR_MASK;
        end
    end

    // Break the register into its fields.
    always_comb begin
        rdata     = cfg_q;
        rx_dma    = cfg_q[RX_DMA_BIT];
        tx_dma    = cfg_q[TX_DMA_BIT];
        full_lvl  = cfg_q[FULL_LVL_LSB +: LW];
        empty_lvl = cfg_q[EMPTY_LVL_LSB +: LW];
    end

endmodule

// File: rtl/xfer_fifo_thresh.sv
// Module: one threshold comparator routing its result to a DMA request or
// to a status flag. ABOVE=1 compares count > level, ABOVE=0 compares
// count < level. Purely combinational; assumes count and level are registered.
module xfer_fifo_thresh #(
    parameter int CW    = 6,
    parameter int LW    = 5,
    parameter bit ABOVE = 1'b1
) (
    input  logic [CW-1:0] count,
    input  logic [LW-1:0] level,
    input  logic          dma_en,
    input  logic          side_sel,
    input  logic          idle,
    output logic          dreq,
    output logic          flag
);

    logic cond;

    generate
        if (ABOVE) begin : g_above
            // Almost-full style comparison.
            assign cond = count > CW'(level);
        end else begin : g_below
            // Almost-empty style comparison.
            assign cond = count < CW'(level);
        end
    endgenerate

    // Send the crossing to exactly one of the two outputs.
    always_comb begin
        dreq = side_sel && !idle && cond && dma_en;
        flag = side_sel && !idle && cond && !dma_en;
    end

endmodule

// File: rtl/xfer_fifo_dreq.sv
// Module: card data FIFO with threshold-driven DMA requests and flags.
// Direction selects the active push/pop pair. Side 0 is receive
// (almost-full), side 1 is transmit (almost-empty). Synchronous active-low reset.
module xfer_fifo_dreq
    import xfer_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dir_rx,
    input  logic                       xfer_active,
    input  logic                       host_push,
    input  logic [DW-1:0]              host_wdata,
    input  logic                       host_pop,
    output logic [DW-1:0]              host_rdata,
    input  logic                       card_push,
    input  logic [DW-1:0]              card_wdata,
    input  logic                       card_pop,
    output logic [DW-1:0]              card_rdata,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_wdata,
    output logic [CFG_W-1:0]           cfg_rdata,
    output logic [$clog2(DEPTH):0]     fill_level,
    output logic                       rx_dreq,
    output logic                       tx_dreq,
    output logic                       rx_flag,
    output logic                       tx_flag
);

    localparam int AW     = $clog2(DEPTH);
    localparam int CW     = AW + 1;
    localparam int LW     = AW;
    localparam int NSIDES = 2;

    xfer_dir_e     dir;
    logic          push_sel;
    logic          pop_sel;
    logic [DW-1:0] wdata_sel;
    logic [DW-1:0] head_word;
    logic [CW-1:0] count;
    logic          idle;

    logic          rx_dma_en;
    logic          tx_dma_en;
    logic [LW-1:0] full_lvl;
    logic [LW-1:0] empty_lvl;

    logic [LW-1:0]     side_lvl [NSIDES];
    logic [NSIDES-1:0] side_dma;
    logic [NSIDES-1:0] side_sel;
    logic [NSIDES-1:0] side_dreq;
    logic [NSIDES-1:0] side_flag;

    // Route the active push/pop pair by direction.
    always_comb begin
        dir       = xfer_dir_e'(dir_rx);
        push_sel  = (dir == DIR_RX) ? card_push  : host_push;
        pop_sel   = (dir == DIR_RX) ? host_pop   : card_pop;
        wdata_sel = (dir == DIR_RX) ? card_wdata : host_wdata;
    end

    xfer_fifo_store #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_sel),
        .wdata (wdata_sel),
        .pop   (pop_sel),
        .rdata (head_word),
        .count (count)
    );

    xfer_fifo_cfg #(
        .DEPTH (DEPTH),
        .LW    (LW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .rx_dma    (rx_dma_en),
        .full_lvl  (full_lvl),
        .tx_dma    (tx_dma_en),
        .empty_lvl (empty_lvl)
    );

    // Idle means no transfer in flight and nothing buffered.
    assign idle = !xfer_active && (count == '0);

    // Gather per-side threshold inputs for the generated comparators.
    always_comb begin
        side_lvl[0] = full_lvl;
        side_lvl[1] = empty_lvl;
        side_dma    = {tx_dma_en, rx_dma_en};
        side_sel    = {(dir == DIR_TX), (dir == DIR_RX)};
    end

    generate
        for (genvar s = 0; s < NSIDES; s++) begin : g_side
            xfer_fifo_thresh #(
                .CW    (CW),
                .LW    (LW),
                .ABOVE ((s == 0) ? 1'b1 : 1'b0)
            ) u_thresh (
                .count    (count),
                .level    (side_lvl[s]),
                .dma_en   (side_dma[s]),
                .side_sel (side_sel[s]),
                .idle     (idle),
                .dreq     (side_dreq[s]),
                .flag     (side_flag[s])
            );
        end
    endgenerate

    // Drive the outputs.
    always_comb begin
        host_rdata = head_word;
        card_rdata = head_word;
        fill_level = count;
        rx_dreq    = side_dreq[0];
        rx_flag    = side_flag[0];
        tx_dreq    = side_dreq[1];
        tx_flag    = side_flag[1];
    end

endmodule

// File: rtl/xfer_fifo_dreq_chk.sv
// Module: property checker for xfer_fifo_dreq, attached by bind below.
// Observes ports only; assumes a synchronous active-low reset.
module xfer_fifo_dreq_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_rx,
    input logic          xfer_active,
    input logic          host_push,
    input logic          host_pop,
    input logic          card_push,
    input logic          card_pop,
    input logic [DW-1:0] host_rdata,
    input logic          cfg_we,
    input logic [15:0]   cfg_wdata,
    input logic [CW-1:0] fill_level,
    input logic          rx_dreq,
    input logic          tx_dreq,
    input logic          rx_flag,
    input logic          tx_flag
);

    logic act_push;
    logic act_pop;
    logic off_push;
    logic off_pop;

    // Active and inactive strobes for the current direction.
    always_comb begin
        act_push = dir_rx ? card_push : host_push;
        act_pop  = dir_rx ? host_pop  : card_pop;
        off_push = dir_rx ? host_push : card_push;
        off_pop  = dir_rx ? card_pop  : host_pop;
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == CW'(DEPTH)) && act_push && !act_pop |=> fill_level == CW'(DEPTH));

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) && act_pop && !act_push |=> (fill_level == '0) && $stable(host_rdata));

    p_ignored_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (off_push || off_pop) && !act_push && !act_pop |=> $stable(fill_level));

    p_rx_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dreq && rx_flag));

    p_tx_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dreq && tx_flag));

    p_side_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx ? (!tx_dreq && !tx_flag) : (!rx_dreq && !rx_flag));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active && (fill_level == '0) |-> $countones({rx_dreq, tx_dreq, rx_flag, tx_flag}) == 0);

    p_rx_enable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[15] |=> !rx_flag);

    p_tx_enable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[7] |=> !tx_flag);

    p_push_pop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act_push && act_pop && (fill_level != '0) && (fill_level != CW'(DEPTH)) |=> $stable(fill_level));

endmodule

bind xfer_fifo_dreq xfer_fifo_dreq_chk #(
    .DW    (DW),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_rx      (dir_rx),
    .xfer_active (xfer_active),
    .host_push   (host_push),
    .host_pop    (host_pop),
    .card_push   (card_push),
    .card_pop    (card_pop),
    .host_rdata  (host_rdata),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .fill_level  (fill_level),
    .rx_dreq     (rx_dreq),
    .tx_dreq     (tx_dreq),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag)
);

// File: tb/xfer_fifo_dreq_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked every
// cycle against a ring-buffer model built from the requirements.
module xfer_fifo_dreq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_rx = 1'b0;
    logic        xfer_active = 1'b0;
    logic        host_push = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [15:0] host_rdata;
    logic        card_push = 1'b0;
    logic [15:0] card_wdata = '0;
    logic        card_pop = 1'b0;
    logic [15:0] card_rdata;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [5:0]  fill_level;
    logic        rx_dreq, tx_dreq, rx_flag, tx_flag;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [15:0] mq [DEPTH];
    bit          known [DEPTH];
    int          m_rd, m_wr, m_cnt;
    int          m_af, m_ae;
    bit          m_rxd, m_txd;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_fifo_dreq u_dut (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .xfer_active(xfer_active),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .card_push(card_push), .card_wdata(card_wdata),
        .card_pop(card_pop), .card_rdata(card_rdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fill_level(fill_level),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .rx_flag(rx_flag), .tx_flag(tx_flag)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_idle();
        return !xfer_active && (m_cnt == 0);
    endfunction
    function automatic bit e_rx_cond();
        return dir_rx && !m_idle() && (m_cnt > m_af);
    endfunction
    function automatic bit e_tx_cond();
        return !dir_rx && !m_idle() && (m_cnt < m_ae);
    endfunction
    function automatic int e_cfg();
        return (int'(m_rxd) << 15) | (m_af << 8) | (int'(m_txd) << 7) | m_ae;
    endfunction

    task automatic model_reset();
        m_rd = 0; m_wr = 0; m_cnt = 0;
        m_af = 31; m_ae = 0; m_rxd = 0; m_txd = 0;
    endtask

    // Update the model with the inputs applied at this edge.
    task automatic model_step();
        bit pu, po, pok, qok;
        logic [15:0] d;
        if (!rst_n) begin
            model_reset();
            return;
        end
        pu  = dir_rx ? card_push : host_push;
        po  = dir_rx ? host_pop  : card_pop;
        d   = dir_rx ? card_wdata : host_wdata;
        pok = pu && (m_cnt < DEPTH);
        qok = po && (m_cnt > 0);
        if (pok) begin
            mq[m_wr] = d; known[m_wr] = 1; m_wr = (m_wr + 1) % DEPTH;
        end
        if (qok) m_rd = (m_rd + 1) % DEPTH;
        m_cnt = m_cnt + int'(pok) - int'(qok);
        if (cfg_we) begin
            m_rxd = cfg_wdata[15]; m_af = int'(cfg_wdata[12:8]);
            m_txd = cfg_wdata[7];  m_ae = int'(cfg_wdata[4:0]);
        end
    endtask

    task automatic compare_all();
        chk("R5", "fill_level", int'(fill_level), m_cnt);
        if (known[m_rd]) begin
            chk("R2", "host_rdata", int'(host_rdata), int'(mq[m_rd]));
            chk("R2", "card_rdata", int'(card_rdata), int'(mq[m_rd]));
        end
        chk("R6", "rx_dreq", int'(rx_dreq), int'(e_rx_cond() && m_rxd));
        chk("R6", "rx_flag", int'(rx_flag), int'(e_rx_cond() && !m_rxd));
        chk("R7", "tx_dreq", int'(tx_dreq), int'(e_tx_cond() && m_txd));
        chk("R7", "tx_flag", int'(tx_flag), int'(e_tx_cond() && !m_txd));
        chk("R10", "cfg_rdata", int'(cfg_rdata), e_cfg());
    endtask

    // One clock: inputs already set at negedge; strobes cleared afterwards.
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
        host_push = 0; host_pop = 0; card_push = 0; card_pop = 0; cfg_we = 0;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we = 1; cfg_wdata = v; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] stale;
        void'($urandom(32'd20240607));
        model_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1", "fill_level", int'(fill_level), 0);
        chk("R1", "cfg_rdata", int'(cfg_rdata), 16'h1F00);
        chk("R1", "outputs", int'({rx_dreq, tx_dreq, rx_flag, tx_flag}), 0);

        // R4: pop on empty in transmit direction
        xfer_active = 1; dir_rx = 0;
        stale = host_rdata;
        card_pop = 1; tick();
        chk("R4", "fill after empty pop", int'(fill_level), 0);
        chk("R4", "head after empty pop", int'(host_rdata), int'(stale));

        // R3: overfill in transmit direction
        for (int k = 0; k < 34; k++) begin
            host_push = 1; host_wdata = 16'hA000 + 16'(k); tick();
        end
        chk("R3", "fill after overfill", int'(fill_level), 32);
        host_push = 1; host_wdata = 16'hBEEF; card_pop = 1; tick();
        chk("R3", "push at full with pop", int'(fill_level), 31);
        chk("R3", "head after full pop", int'(card_rdata), 16'hA001);

        // R2: drain, then stream across the wrap point
        for (int k = 0; k < 31; k++) begin
            card_pop = 1; tick();
        end
        stale = host_rdata;
        card_pop = 1; tick();
        chk("R4", "stale head on empty", int'(host_rdata), int'(stale));
        for (int k = 0; k < 40; k++) begin
            host_push = 1; host_wdata = 16'hC000 + 16'(k);
            card_pop = (k > 2); tick();
        end

        // R11: simultaneous push and pop
        host_push = 1; host_wdata = 16'h1234; card_pop = 1; tick();
        chk("R11", "fill on push+pop", int'(fill_level), 3);
        repeat (3) begin card_pop = 1; tick(); end

        // R5: ignored strobes in each direction
        card_push = 1; card_wdata = 16'h5555; host_pop = 1; tick();
        chk("R5", "tx ignores card push", int'(fill_level), 0);
        dir_rx = 1;
        host_push = 1; host_wdata = 16'h6666; tick();
        chk("R5", "rx ignores host push", int'(fill_level), 0);

        // R6 / R8 / R10: receive threshold
        write_cfg(16'h0403);
        chk("R8", "tx quiet in rx", int'({tx_dreq, tx_flag}), 0);
        for (int k = 0; k < 5; k++) begin
            card_push = 1; card_wdata = 16'h7000 + 16'(k); tick();
        end
        chk("R6", "rx flag above level", int'(rx_flag), 1);
        write_cfg(16'h8403);
        chk("R10", "rx flag cleared by enable", int'(rx_flag), 0);
        chk("R6", "rx dreq above level", int'(rx_dreq), 1);
        host_pop = 1; tick();
        chk("R8", "rx low at level", int'({rx_dreq, rx_flag}), 0);
        repeat (4) begin host_pop = 1; tick(); end

        // R9 / R7 / R10: transmit threshold against idle
        dir_rx = 0; xfer_active = 0;
        write_cfg(16'h1F03);
        chk("R9", "idle quiet", int'({rx_dreq, tx_dreq, rx_flag, tx_flag}), 0);
        xfer_active = 1; tick();
        chk("R7", "tx flag below level", int'(tx_flag), 1);
        write_cfg(16'h1F83);
        chk("R10", "tx flag cleared by enable", int'(tx_flag), 0);
        chk("R7", "tx dreq below level", int'(tx_dreq), 1);
        write_cfg(16'hFFFF);
        chk("R10", "reserved bits", int'(cfg_rdata), 16'h9F9F);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(63) == 0) dir_rx = ~dir_rx;
            if ($urandom_range(31) == 0) xfer_active = ~xfer_active;
            if ($urandom_range(39) == 0) begin
                cfg_we = 1; cfg_wdata = 16'($urandom);
            end
            host_push = 1'($urandom); host_pop = 1'($urandom);
            card_push = 1'($urandom); card_pop = 1'($urandom);
            host_wdata = 16'($urandom); card_wdata = 16'($urandom);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule